// File: doc/BRIEF.md
# Bus-master DMA channel control and status unit

This unit holds the per-channel registers of a bus-master disk DMA controller and judges how a transfer ended. Software reaches three registers over a small word-addressed bus that has byte enables: a command register with a start bit and a transfer-direction bit, a status register, and a 32-bit descriptor table pointer. A separate transfer engine drives a level that shows it is moving data. It also sends single-cycle pulses to report an error or a completion interrupt. The unit turns these into sticky status flags that software clears by writing them back as ones.

Two one-shot queries sit beside the registers. An end-of-transfer query reports whether the status shows a clean finish and, if it does not, returns the status byte with a fault marker. A timeout query decides whether to keep waiting, fail the request, or reset the bus. This decision is made by a two-state grace machine. In state GR_ARMED the first ordinary timeout is allowed to wait. That timeout moves the machine to GR_SPENT (transition "consume"), and from GR_SPENT every later timeout fails. A 0-to-1 write of the start bit returns the machine to GR_ARMED (transition "rearm") from either state. A timeout that sees status bits 3 and 4 both set leaves the machine in GR_ARMED (transition "hold").

Top module: `bmdma_channel`

## Requirements
- R1: After reset the command register, the status register and the table pointer all read zero, the grace machine is in GR_ARMED, and end_valid and tmo_valid are low.
- R2: The command register is at address 0. Bit 0 is start and drives ctl_start. Bit 3 is direction, where 1 means data flows from the device into memory, and it drives ctl_to_mem. All other bits read zero. A write needs bus_be[0].
- R3: The table pointer is at address 2. Each byte is written under its own bus_be bit. The low PTR_LSB bits always read zero, and tbl_ptr shows the masked value.
- R4: Status bit 0 (active) always equals eng_active. Writes do not change it.
- R5: Status bit 1 (error) and bit 2 (interrupt) are set by eng_err_pulse and eng_irq_pulse and stay set. A status write (address 1, bus_be[0]) with a 1 in that bit clears it, and a 0 has no effect. An engine pulse in the same cycle as a clear leaves the flag set.
- R6: Status bits 3 to 6 are read/write. Bits 5 and 6 are the drive 0 and drive 1 DMA-capable flags and appear on drv_dma_ok[0] and drv_dma_ok[1]. Bit 7 reads zero.
- R7: irq_pending equals status bit 2.
- R8: One cycle after end_req, end_valid is high. end_code is 0x00 if status bits 2..0 equal 3'b100, and otherwise it is 0x10 OR the status byte sampled with end_req.
- R9: One cycle after tmo_req in GR_ARMED, tmo_valid is high and tmo_code is chosen by status. If bits 3 and 4 are both set, the code is WAIT (1) and the machine stays armed. Otherwise the machine moves to GR_SPENT, and the code is FAIL (2) if error is set, WAIT (1) if active or interrupt is set, and BUS_RESET (0) if none of them is set.
- R10: In GR_SPENT every tmo_req yields FAIL (2). Only a write that takes the start bit from 0 to 1 rearms the machine. Writing 1 while start is already 1 does not rearm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 command, 1 status, 2 table pointer |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_active | input | 1 | Engine is transferring |
| eng_err_pulse | input | 1 | Engine error event |
| eng_irq_pulse | input | 1 | Engine completion interrupt event |
| ctl_start | output | 1 | Start bit |
| ctl_to_mem | output | 1 | Direction bit, device to memory |
| tbl_ptr | output | 32 | Aligned descriptor table address |
| drv_dma_ok | output | 2 | Per-drive DMA-capable flags |
| irq_pending | output | 1 | Interrupt status bit |
| end_req | input | 1 | End-of-transfer query |
| end_valid | output | 1 | end_code valid |
| end_code | output | 8 | 0 = good, else 0x10 OR status |
| tmo_req | input | 1 | Timeout query |
| tmo_valid | output | 1 | tmo_code valid |
| tmo_code | output | 2 | 0 BUS_RESET, 1 WAIT, 2 FAIL |

## Verification
The bench builds the unit with PTR_LSB = 2, so a table pointer write with ones in bits 1..0 shows the alignment mask, and a single-byte write shows that the byte lanes are independent. It walks all eight combinations of the active, error and interrupt flags through the end-of-transfer query. It then drives the grace machine through hold, consume, spent and rearm, and confirms that rewriting a start bit that is already 1 does not rearm it.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam logic [1:0] ADR_CMD  = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_PTR  = 2'd2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam logic [7:0] CMD_MASK = 8'h09;

    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_RW_LO = 3;
    localparam int ST_RW_W  = 4;

    localparam logic [7:0] END_FAULT = 8'h10;

    typedef enum logic [1:0] {
        TMO_BUS_RESET = 2'd0,
        TMO_WAIT      = 2'd1,
        TMO_FAIL      = 2'd2
    } tmo_code_e;

    typedef enum logic [0:0] {
        GR_ARMED = 1'b0,
        GR_SPENT = 1'b1
    } grace_e;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int PTR_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    input  logic             eng_active,
    input  logic             eng_err_pulse,
    input  logic             eng_irq_pulse,
    output logic [7:0]       cmd_q,
    output logic [7:0]       stat_q,
    output logic [PTR_W-1:0] ptr_q,
    output logic             start_rise
);
    localparam int NBYTES = PTR_W / 8;
    localparam logic [PTR_W-1:0] PTR_MASK = ~((PTR_W'(1) << PTR_LSB) - PTR_W'(1));

    logic wr_cmd, wr_stat, wr_ptr;
    logic err_q, irq_q;
    logic [ST_RW_W-1:0] rw_q;
    logic [PTR_W-1:0] ptr_raw;

    assign wr_cmd  = bus_en && bus_we && (bus_addr == ADR_CMD)  && bus_be[0];
    assign wr_stat = bus_en && bus_we && (bus_addr == ADR_STAT) && bus_be[0];
    assign wr_ptr  = bus_en && bus_we && (bus_addr == ADR_PTR);

    assign start_rise = wr_cmd && bus_wdata[CMD_START_BIT] && !cmd_q[CMD_START_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= bus_wdata[7:0] & CMD_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            rw_q  <= '0;
        end else begin
            err_q <= eng_err_pulse | (err_q & ~(wr_stat & bus_wdata[ST_ERR]));
            irq_q <= eng_irq_pulse | (irq_q & ~(wr_stat & bus_wdata[ST_IRQ]));
            if (wr_stat) begin
                rw_q <= bus_wdata[ST_RW_LO +: ST_RW_W];
            end
        end
    end

    assign stat_q = {1'b0, rw_q, irq_q, err_q, eng_active};

    for (genvar b = 0; b < NBYTES; b++) begin : g_ptr_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_raw[8*b +: 8] <= 8'h00;
            end else if (wr_ptr && bus_be[b]) begin
                ptr_raw[8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end
    end

    assign ptr_q = ptr_raw & PTR_MASK;
endmodule

// File: rtl/bmdma_judge.sv
module bmdma_judge
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       end_req,
    input  logic       tmo_req,
    input  logic       rearm,
    input  logic [7:0] stat,
    output logic       end_valid,
    output logic [7:0] end_code,
    output logic       tmo_valid,
    output tmo_code_e  tmo_code
);
    grace_e    state_q, state_d;
    tmo_code_e decision;
    logic      end_good;

    assign end_good = (stat[ST_IRQ:ST_ACT] == 3'b100);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GR_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        decision = TMO_BUS_RESET;
        if (tmo_req) begin
            unique case (state_q)
                GR_ARMED: begin
                    if (stat[4:3] == 2'b11) begin
                        decision = TMO_WAIT;
                    end else begin
                        state_d = GR_SPENT;
                        if (stat[ST_ERR])
                            decision = TMO_FAIL;
                        else if (stat[ST_ACT] || stat[ST_IRQ])
                            decision = TMO_WAIT;
                        else
                            decision = TMO_BUS_RESET;
                    end
                end
                GR_SPENT: decision = TMO_FAIL;
            endcase
        end
        if (rearm) begin
            state_d = GR_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_valid <= 1'b0;
            end_code  <= 8'h00;
            tmo_valid <= 1'b0;
            tmo_code  <= TMO_BUS_RESET;
        end else begin
            end_valid <= end_req;
            if (end_req) begin
                end_code <= end_good ? 8'h00 : (END_FAULT | stat);
            end
            tmo_valid <= tmo_req;
            if (tmo_req) begin
                tmo_code <= decision;
            end
        end
    end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
#(
    parameter int PTR_LSB = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        eng_active,
    input  logic        eng_err_pulse,
    input  logic        eng_irq_pulse,
    output logic        ctl_start,
    output logic        ctl_to_mem,
    output logic [31:0] tbl_ptr,
    output logic [1:0]  drv_dma_ok,
    output logic        irq_pending,
    input  logic        end_req,
    output logic        end_valid,
    output logic [7:0]  end_code,
    input  logic        tmo_req,
    output logic        tmo_valid,
    output logic [1:0]  tmo_code
);
    logic [7:0]  cmd_q;
    logic [7:0]  stat_q;
    logic [31:0] ptr_q;
    logic        start_rise;
    tmo_code_e   tmo_code_w;

    bmdma_regs #(.PTR_W(32), .PTR_LSB(PTR_LSB)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .eng_active    (eng_active),
        .eng_err_pulse (eng_err_pulse),
        .eng_irq_pulse (eng_irq_pulse),
        .cmd_q         (cmd_q),
        .stat_q        (stat_q),
        .ptr_q         (ptr_q),
        .start_rise    (start_rise)
    );

    bmdma_judge u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_req   (end_req),
        .tmo_req   (tmo_req),
        .rearm     (start_rise),
        .stat      (stat_q),
        .end_valid (end_valid),
        .end_code  (end_code),
        .tmo_valid (tmo_valid),
        .tmo_code  (tmo_code_w)
    );

    always_comb begin
        unique case (bus_addr)
            ADR_CMD:  bus_rdata = {24'h0, cmd_q};
            ADR_STAT: bus_rdata = {24'h0, stat_q};
            ADR_PTR:  bus_rdata = ptr_q;
            default:  bus_rdata = 32'h0;
        endcase
    end

    assign ctl_start   = cmd_q[CMD_START_BIT];
    assign ctl_to_mem  = cmd_q[CMD_DIR_BIT];
    assign tbl_ptr     = ptr_q;
    assign drv_dma_ok  = stat_q[6:5];
    assign irq_pending = stat_q[ST_IRQ];
    assign tmo_code    = tmo_code_w;
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic        eng_err_pulse,
    input logic        eng_irq_pulse,
    input logic [7:0]  stat_q,
    input logic        ctl_start,
    input logic        irq_pending,
    input logic        end_req,
    input logic        end_valid,
    input logic [7:0]  end_code,
    input logic        tmo_req,
    input logic [1:0]  tmo_code
);
    logic clr_irq, cmd_start_wr;
    assign clr_irq = bus_en && bus_we && (bus_addr == 2'd1) && bus_be[0] && bus_wdata[2];
    assign cmd_start_wr = bus_en && bus_we && (bus_addr == 2'd0) && bus_be[0] && bus_wdata[0];

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_pulse |=> irq_pending); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending && !clr_irq |=> irq_pending); // R5
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err_pulse |=> stat_q[1]); // R5
    AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_start && !cmd_start_wr |=> !ctl_start); // R2
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        end_req |=> end_valid); // R8
    AST_END_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        end_req && (stat_q[2:0] == 3'b100) |=> end_code == 8'h00); // R8
    AST_END_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        end_req && (stat_q[2:0] != 3'b100) |=> end_code[4]); // R8
    AST_TMO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req && stat_q[1] && (stat_q[4:3] != 2'b11) |=> tmo_code == 2'd2); // R9
endmodule

bind bmdma_channel bmdma_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_be        (bus_be),
    .bus_wdata     (bus_wdata),
    .eng_err_pulse (eng_err_pulse),
    .eng_irq_pulse (eng_irq_pulse),
    .stat_q        (stat_q),
    .ctl_start     (ctl_start),
    .irq_pending   (irq_pending),
    .end_req       (end_req),
    .end_valid     (end_valid),
    .end_code      (end_code),
    .tmo_req       (tmo_req),
    .tmo_code      (tmo_code)
);

// File: tb/sim_bmdma_channel.sv
`timescale 1ns/1ps
module sim_bmdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        eng_active = 1'b0, eng_err_pulse = 1'b0, eng_irq_pulse = 1'b0;
    logic        ctl_start, ctl_to_mem, irq_pending, end_valid, tmo_valid;
    logic [31:0] tbl_ptr;
    logic [1:0]  drv_dma_ok, tmo_code;
    logic [7:0]  end_code;
    logic        end_req = 1'b0, tmo_req = 1'b0;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bmdma_channel #(.PTR_LSB(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_active(eng_active),
        .eng_err_pulse(eng_err_pulse), .eng_irq_pulse(eng_irq_pulse),
        .ctl_start(ctl_start), .ctl_to_mem(ctl_to_mem), .tbl_ptr(tbl_ptr),
        .drv_dma_ok(drv_dma_ok), .irq_pending(irq_pending),
        .end_req(end_req), .end_valid(end_valid), .end_code(end_code),
        .tmo_req(tmo_req), .tmo_valid(tmo_valid), .tmo_code(tmo_code)
    );

    // {active, error, interrupt, expected end_code}
    localparam logic [10:0] END_VEC [8] = '{
        {3'b000, 8'h10}, {3'b100, 8'h11}, {3'b010, 8'h12}, {3'b110, 8'h13},
        {3'b001, 8'h00}, {3'b101, 8'h15}, {3'b011, 8'h16}, {3'b111, 8'h17}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic e, input logic i);
        @(negedge clk);
        eng_err_pulse = e; eng_irq_pulse = i;
        @(negedge clk);
        eng_err_pulse = 1'b0; eng_irq_pulse = 1'b0;
    endtask

    task automatic tmo_query(input string req, input logic [1:0] exp);
        @(negedge clk);
        tmo_req = 1'b1;
        @(negedge clk);
        tmo_req = 1'b0;
        chk(req, {31'b0, tmo_valid}, 32'd1);
        chk(req, {30'b0, tmo_code}, {30'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 cmd", d, 32'h0);
        rd(2'd1, d); chk("R1 stat", d, 32'h0);
        rd(2'd2, d); chk("R1 ptr", d, 32'h0);
        chk("R1 valids", {30'b0, end_valid, tmo_valid}, 32'h0);

        // R8 table walk
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, 4'h1, 32'h06);
            @(negedge clk);
            eng_active = END_VEC[i][10];
            pulse(END_VEC[i][9], END_VEC[i][8]);
            @(negedge clk);
            end_req = 1'b1;
            @(negedge clk);
            end_req = 1'b0;
            chk("R8 valid", {31'b0, end_valid}, 32'd1);
            chk("R8 code", {24'b0, end_code}, {24'b0, END_VEC[i][7:0]});
            eng_active = 1'b0;
        end
        wr(2'd1, 4'h1, 32'h06);

        // R2 command register
        wr(2'd0, 4'h1, 32'hFF);
        rd(2'd0, d); chk("R2 cmd read", d, 32'h09);
        chk("R2 outs", {30'b0, ctl_start, ctl_to_mem}, 32'h3);
        wr(2'd0, 4'h0, 32'h00);
        chk("R2 no be", {31'b0, ctl_start}, 32'd1);
        wr(2'd0, 4'h1, 32'h00);
        chk("R2 stop", {30'b0, ctl_start, ctl_to_mem}, 32'h0);

        // R3 pointer
        wr(2'd2, 4'hF, 32'hDEADBEEF);
        rd(2'd2, d); chk("R3 align", d, 32'hDEADBEEC);
        chk("R3 port", tbl_ptr, 32'hDEADBEEC);
        wr(2'd2, 4'h2, 32'h00005500);
        rd(2'd2, d); chk("R3 lane", d, 32'hDEAD55EC);

        // R4 active read-only
        wr(2'd1, 4'h1, 32'h01);
        rd(2'd1, d); chk("R4 write ignored", d, 32'h08 & 32'h0);
        eng_active = 1'b1;
        rd(2'd1, d); chk("R4 follows", d, 32'h01);
        eng_active = 1'b0;

        // R5 sticky / W1C / set wins, R7
        pulse(1'b1, 1'b1);
        rd(2'd1, d); chk("R5 set", d, 32'h06);
        chk("R7 irq", {31'b0, irq_pending}, 32'd1);
        wr(2'd1, 4'h1, 32'h00);
        rd(2'd1, d); chk("R5 zero no effect", d, 32'h06);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_be = 4'h1; bus_wdata = 32'h06;
        eng_irq_pulse = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0; eng_irq_pulse = 1'b0;
        rd(2'd1, d); chk("R5 set wins", d, 32'h04);
        wr(2'd1, 4'h1, 32'h04);
        rd(2'd1, d); chk("R5 clear", d, 32'h00);
        chk("R7 irq clear", {31'b0, irq_pending}, 32'd0);

        // R6 rw bits
        wr(2'd1, 4'h1, 32'hF8);
        rd(2'd1, d); chk("R6 rw", d, 32'h78);
        chk("R6 drives", {30'b0, drv_dma_ok}, 32'h3);
        wr(2'd1, 4'h1, 32'h20);
        chk("R6 drive0", {30'b0, drv_dma_ok}, 32'h1);
        wr(2'd1, 4'h1, 32'h00);

        // R9 / R10 grace machine
        wr(2'd0, 4'h1, 32'h01);
        wr(2'd1, 4'h1, 32'h18);
        tmo_query("R9 hold", 2'd1);
        tmo_query("R9 hold again", 2'd1);
        wr(2'd1, 4'h1, 32'h00);
        eng_active = 1'b1;
        tmo_query("R9 active wait", 2'd1);
        tmo_query("R10 spent", 2'd2);
        eng_active = 1'b0;
        wr(2'd0, 4'h1, 32'h01);
        tmo_query("R10 no rearm when high", 2'd2);
        wr(2'd0, 4'h1, 32'h00);
        wr(2'd0, 4'h1, 32'h01);
        tmo_query("R9 bus reset", 2'd0);
        tmo_query("R10 spent after reset", 2'd2);
        wr(2'd0, 4'h1, 32'h00);
        wr(2'd0, 4'h1, 32'h01);
        pulse(1'b1, 1'b0);
        tmo_query("R9 error fail", 2'd2);
        wr(2'd1, 4'h1, 32'h02);
        wr(2'd0, 4'h1, 32'h00);
        wr(2'd0, 4'h1, 32'h01);
        pulse(1'b0, 1'b1);
        tmo_query("R9 irq wait", 2'd1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule